// File: doc/BRIEF.md
# Reversible Register Execution Unit

This block is the execution stage of a 16-bit processor whose programs can run in either direction. Each cycle it may accept one decoded operation with up to three register indices, the three register values read for them, an immediate and the current direction bit. One cycle later it returns up to two register write-backs, each with its own index, value and write enable. The register file, fetch, memory exchange and branching sit outside the block.

Every operation maps register state to register state one-to-one. When the direction bit is set, the unit executes the inverse of the operation it was given: additions become subtractions, left rotations become right rotations, and the remaining operations are their own inverses. Running a sequence forward and then backward returns the registers to their earlier values. Forms that would lose information because the destination is also a source are reported as illegal and write nothing. Reserved opcodes are reported the same way.

Top module: `rev_alu`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_valid`, `out_illegal`, `out_we_a` and `out_we_b` are 0.
- R2: Results appear on the outputs exactly one clock after the operation is presented with `in_valid`=1. `out_valid` equals the previous cycle's `in_valid`. No write enable is ever high unless `out_valid` is high.
- R3: Opcodes are `in_op` codes 0 nop, 1 not, 2 swap, 3 xor, 4 add, 5 sub, 6 rotl, 7 rotr, 8 xori, 9 addi, 10 subi, 11 rotli, 12 rotri, 13 ccn, 14 cswap. Code 15 is reserved. nop writes nothing.
- R4: not (`~va`), xor (`va^vb`), xori (`va^imm`) and ccn (`va ^ (vb & vc)`) write port A at index `in_ia`. Each gives the same result for either value of `in_dir`.
- R5: add/addi give `va+src` and sub/subi give `va-src` modulo 2^16, with no flags, when `in_dir`=0. When `in_dir`=1, add behaves as sub and sub behaves as add. The result is written on port A at index `in_ia`.
- R6: Rotations use the low 4 bits of `vb` (register forms) or of `imm` (immediate forms) as the amount, so the amount is taken modulo 16. When `in_dir`=1, left and right rotations are exchanged. The result is written on port A at index `in_ia`.
- R7: swap writes `vb` on port A at index `in_ia` and `va` on port B at index `in_ib`, in both directions.
- R8: cswap uses `va` as a per-bit mask. Port A, at index `in_ib`, gets `vb` with the masked bits taken from `vc`. Port B, at index `in_ic`, gets `vc` with the masked bits taken from `vb`. The result is the same in both directions.
- R9: `out_illegal`=1 and neither write enable is set in these cases: xor, add, sub, rotl or rotr with `in_ia`==`in_ib`; ccn with `in_ia` equal to `in_ib` or to `in_ic`; or opcode 15.
- R10: An operation followed by the same operation with `in_dir`=1, applied to the first result, restores the original port A value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Opcode (see R3) |
| in_dir | input | 1 | 1 = execute the inverse operation |
| in_ia | input | 3 | First register index |
| in_ib | input | 3 | Second register index |
| in_ic | input | 3 | Third register index |
| in_va | input | 16 | Value of first register |
| in_vb | input | 16 | Value of second register |
| in_vc | input | 16 | Value of third register |
| in_imm | input | 16 | Immediate operand |
| out_valid | output | 1 | Result present |
| out_illegal | output | 1 | Operation rejected, nothing written |
| out_we_a | output | 1 | Write enable, port A |
| out_idx_a | output | 3 | Register index, port A |
| out_val_a | output | 16 | Write value, port A |
| out_we_b | output | 1 | Write enable, port B |
| out_idx_b | output | 3 | Register index, port B |
| out_val_b | output | 16 | Write value, port B |

## Verification
Arithmetic is tried with operands that wrap past 0xFFFF and below zero, in both directions, so that a missing add/sub exchange or a carry fault shows up. Rotations use amounts 0, 1, 15 and values above 15, which separate true modulo-16 rotation from plain shifts and from wrong direction handling. The self-inverse operations and both swaps are given asymmetric bit patterns under both direction values, and the destination routing is checked on both ports. Aliased indices, the reserved code and forward-then-reverse pairs show that illegal forms never write and that legal forms undo themselves.

// File: rtl/rev_alu_pkg.sv
package rev_alu_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_NOT   = 4'd1,
    OP_SWP   = 4'd2,
    OP_XOR   = 4'd3,
    OP_ADD   = 4'd4,
    OP_SUB   = 4'd5,
    OP_ROL   = 4'd6,
    OP_ROR   = 4'd7,
    OP_XORI  = 4'd8,
    OP_ADDI  = 4'd9,
    OP_SUBI  = 4'd10,
    OP_ROLI  = 4'd11,
    OP_RORI  = 4'd12,
    OP_CCN   = 4'd13,
    OP_CSWP  = 4'd14,
    OP_RSVD  = 4'd15
  } op_e;
endpackage

// File: rtl/rev_alu_rot.sv
module rev_alu_rot #(
  parameter int W    = 16,
  parameter bit LEFT = 1'b1,
  localparam int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    dout
);
  logic [W-1:0] stg [SH_W+1];

  assign stg[0] = din;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [W-1:0] moved;
    if (LEFT) begin : g_l
      assign moved = {stg[k][W-1-STEP:0], stg[k][W-1:W-STEP]};
    end else begin : g_r
      assign moved = {stg[k][STEP-1:0], stg[k][W-1:STEP]};
    end
    assign stg[k+1] = amt[k] ? moved : stg[k];
  end

  assign dout = stg[SH_W];
endmodule

// File: rtl/rev_alu_opmap.sv
module rev_alu_opmap
  import rev_alu_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  op_e              op_in,
  input  logic             dir,
  input  logic [IDX_W-1:0] ia,
  input  logic [IDX_W-1:0] ib,
  input  logic [IDX_W-1:0] ic,
  output op_e              op_eff,
  output logic             illegal
);
  always_comb begin
    op_eff = op_in;
    if (dir) begin
      unique case (op_in)
        OP_ADD:  op_eff = OP_SUB;
        OP_SUB:  op_eff = OP_ADD;
        OP_ADDI: op_eff = OP_SUBI;
        OP_SUBI: op_eff = OP_ADDI;
        OP_ROL:  op_eff = OP_ROR;
        OP_ROR:  op_eff = OP_ROL;
        OP_ROLI: op_eff = OP_RORI;
        OP_RORI: op_eff = OP_ROLI;
        default: op_eff = op_in;
      endcase
    end
  end

  always_comb begin
    unique case (op_in)
      OP_XOR, OP_ADD, OP_SUB, OP_ROL, OP_ROR: illegal = (ia == ib);
      OP_CCN:  illegal = (ia == ib) || (ia == ic);
      OP_RSVD: illegal = 1'b1;
      default: illegal = 1'b0;
    endcase
  end
endmodule

// File: rtl/rev_alu_datapath.sv
module rev_alu_datapath
  import rev_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  op_e               op,
  input  logic [IDX_W-1:0]  ia,
  input  logic [IDX_W-1:0]  ib,
  input  logic [IDX_W-1:0]  ic,
  input  logic [DATA_W-1:0] va,
  input  logic [DATA_W-1:0] vb,
  input  logic [DATA_W-1:0] vc,
  input  logic [DATA_W-1:0] imm,
  output logic              we_a,
  output logic [IDX_W-1:0]  idx_a,
  output logic [DATA_W-1:0] val_a,
  output logic              we_b,
  output logic [IDX_W-1:0]  idx_b,
  output logic [DATA_W-1:0] val_b
);
  logic              use_imm;
  logic [DATA_W-1:0] src;
  logic [SH_W-1:0]   amt;
  logic [DATA_W-1:0] rot_l, rot_r;

  assign use_imm = (op == OP_XORI) || (op == OP_ADDI) || (op == OP_SUBI) ||
                   (op == OP_ROLI) || (op == OP_RORI);
  assign src     = use_imm ? imm : vb;
  assign amt     = src[SH_W-1:0];

  rev_alu_rot #(.W(DATA_W), .LEFT(1'b1)) u_rot_l (.din(va), .amt(amt), .dout(rot_l));
  rev_alu_rot #(.W(DATA_W), .LEFT(1'b0)) u_rot_r (.din(va), .amt(amt), .dout(rot_r));

  always_comb begin
    we_a  = 1'b0;
    idx_a = ia;
    val_a = '0;
    we_b  = 1'b0;
    idx_b = ib;
    val_b = '0;
    unique case (op)
      OP_NOT: begin we_a = 1'b1; val_a = ~va; end
      OP_SWP: begin
        we_a = 1'b1; val_a = vb;
        we_b = 1'b1; val_b = va;
      end
      OP_XOR, OP_XORI: begin we_a = 1'b1; val_a = va ^ src; end
      OP_ADD, OP_ADDI: begin we_a = 1'b1; val_a = va + src; end
      OP_SUB, OP_SUBI: begin we_a = 1'b1; val_a = va - src; end
      OP_ROL, OP_ROLI: begin we_a = 1'b1; val_a = rot_l; end
      OP_ROR, OP_RORI: begin we_a = 1'b1; val_a = rot_r; end
      OP_CCN: begin we_a = 1'b1; val_a = va ^ (vb & vc); end
      OP_CSWP: begin
        we_a = 1'b1; idx_a = ib; val_a = (vb & ~va) | (vc & va);
        we_b = 1'b1; idx_b = ic; val_b = (vc & ~va) | (vb & va);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rev_alu.sv
module rev_alu
  import rev_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_N  = 8,
  localparam int IDX_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        in_op,
  input  logic              in_dir,
  input  logic [IDX_W-1:0]  in_ia,
  input  logic [IDX_W-1:0]  in_ib,
  input  logic [IDX_W-1:0]  in_ic,
  input  logic [DATA_W-1:0] in_va,
  input  logic [DATA_W-1:0] in_vb,
  input  logic [DATA_W-1:0] in_vc,
  input  logic [DATA_W-1:0] in_imm,
  output logic              out_valid,
  output logic              out_illegal,
  output logic              out_we_a,
  output logic [IDX_W-1:0]  out_idx_a,
  output logic [DATA_W-1:0] out_val_a,
  output logic              out_we_b,
  output logic [IDX_W-1:0]  out_idx_b,
  output logic [DATA_W-1:0] out_val_b
);
  op_e               op_eff;
  logic              bad;
  logic              we_a, we_b;
  logic [IDX_W-1:0]  idx_a, idx_b;
  logic [DATA_W-1:0] val_a, val_b;

  rev_alu_opmap #(.IDX_W(IDX_W)) u_opmap (
    .op_in   (op_e'(in_op)),
    .dir     (in_dir),
    .ia      (in_ia),
    .ib      (in_ib),
    .ic      (in_ic),
    .op_eff  (op_eff),
    .illegal (bad)
  );

  rev_alu_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .op    (op_eff),
    .ia    (in_ia),
    .ib    (in_ib),
    .ic    (in_ic),
    .va    (in_va),
    .vb    (in_vb),
    .vc    (in_vc),
    .imm   (in_imm),
    .we_a  (we_a),
    .idx_a (idx_a),
    .val_a (val_a),
    .we_b  (we_b),
    .idx_b (idx_b),
    .val_b (val_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_we_a    <= 1'b0;
      out_we_b    <= 1'b0;
      out_idx_a   <= '0;
      out_idx_b   <= '0;
      out_val_a   <= '0;
      out_val_b   <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && bad;
      out_we_a    <= in_valid && !bad && we_a;
      out_we_b    <= in_valid && !bad && we_b;
      out_idx_a   <= idx_a;
      out_idx_b   <= idx_b;
      out_val_a   <= val_a;
      out_val_b   <= val_b;
    end
  end
endmodule

// File: rtl/rev_alu_checker.sv
module rev_alu_checker #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        in_op,
  input logic              in_dir,
  input logic [IDX_W-1:0]  in_ia,
  input logic [IDX_W-1:0]  in_ib,
  input logic [DATA_W-1:0] in_va,
  input logic [DATA_W-1:0] in_vb,
  input logic              out_valid,
  input logic              out_illegal,
  input logic              out_we_a,
  input logic [DATA_W-1:0] out_val_a,
  input logic              out_we_b,
  input logic [DATA_W-1:0] out_val_b
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_illegal && !out_we_a && !out_we_b));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_we_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (out_we_a || out_we_b) |-> out_valid);

  assert_not_any_dir_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd1) |=> (out_we_a && out_val_a == ~$past(in_va)));

  assert_add_dir_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd4 && in_ia != in_ib) |=>
      (out_we_a && out_val_a == ($past(in_dir) ? $past(in_va) - $past(in_vb)
                                               : $past(in_va) + $past(in_vb))));

  assert_swap_ports_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd2) |=>
      (out_we_a && out_we_b && out_val_a == $past(in_vb) && out_val_b == $past(in_va)));

  assert_illegal_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (!out_we_a && !out_we_b));

  assert_reserved_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd15) |=> out_illegal);
endmodule

bind rev_alu rev_alu_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_dir(in_dir),
  .in_ia(in_ia), .in_ib(in_ib), .in_va(in_va), .in_vb(in_vb),
  .out_valid(out_valid), .out_illegal(out_illegal), .out_we_a(out_we_a),
  .out_val_a(out_val_a), .out_we_b(out_we_b), .out_val_b(out_val_b)
);

// File: tb/rev_alu_tb.sv
module rev_alu_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  in_op;
  logic        in_dir;
  logic [2:0]  in_ia, in_ib, in_ic;
  logic [15:0] in_va, in_vb, in_vc, in_imm;
  logic        out_valid, out_illegal, out_we_a, out_we_b;
  logic [2:0]  out_idx_a, out_idx_b;
  logic [15:0] out_val_a, out_val_b;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rev_alu u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_dir(in_dir),
    .in_ia(in_ia), .in_ib(in_ib), .in_ic(in_ic),
    .in_va(in_va), .in_vb(in_vb), .in_vc(in_vc), .in_imm(in_imm),
    .out_valid(out_valid), .out_illegal(out_illegal),
    .out_we_a(out_we_a), .out_idx_a(out_idx_a), .out_val_a(out_val_a),
    .out_we_b(out_we_b), .out_idx_b(out_idx_b), .out_val_b(out_val_b)
  );

  function automatic logic [15:0] ref_rotl(input logic [15:0] x, input int s);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[(i + s) % 16] = x[i];
    return r;
  endfunction

  function automatic logic [15:0] ref_rotr(input logic [15:0] x, input int s);
    return ref_rotl(x, (16 - (s % 16)) % 16);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // At a falling edge: present one operation, then wait one cycle for the result.
  task automatic issue(input logic [3:0] op, input logic dir, input logic [2:0] ia,
                       input logic [2:0] ib, input logic [2:0] ic, input logic [15:0] va,
                       input logic [15:0] vb, input logic [15:0] vc, input logic [15:0] imm);
    in_valid = 1'b1; in_op = op; in_dir = dir;
    in_ia = ia; in_ib = ib; in_ic = ic;
    in_va = va; in_vb = vb; in_vc = vc; in_imm = imm;
    @(negedge clk);
  endtask

  task automatic expect_a(input string req, input logic [2:0] idx, input logic [15:0] val);
    chk(req, "valid", out_valid, 1);
    chk(req, "illegal", out_illegal, 0);
    chk(req, "we_a", out_we_a, 1);
    chk(req, "we_b", out_we_b, 0);
    chk(req, "idx_a", out_idx_a, idx);
    chk(req, "val_a", out_val_a, val);
  endtask

  task automatic expect_ab(input string req, input logic [2:0] ia, input logic [15:0] va,
                           input logic [2:0] ib, input logic [15:0] vb);
    chk(req, "valid", out_valid, 1);
    chk(req, "we_a", out_we_a, 1);
    chk(req, "we_b", out_we_b, 1);
    chk(req, "idx_a", out_idx_a, ia);
    chk(req, "val_a", out_val_a, va);
    chk(req, "idx_b", out_idx_b, ib);
    chk(req, "val_b", out_val_b, vb);
  endtask

  task automatic expect_reject(input string req);
    chk(req, "valid", out_valid, 1);
    chk(req, "illegal", out_illegal, 1);
    chk(req, "we_a", out_we_a, 0);
    chk(req, "we_b", out_we_b, 0);
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b1; in_op = 4'd1; in_dir = 1'b0;
    in_ia = 3'd1; in_ib = 3'd2; in_ic = 3'd3;
    in_va = 16'h1234; in_vb = 16'h0; in_vc = 16'h0; in_imm = 16'h0;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", out_valid, 0);
    chk("R1", "we_a in reset", out_we_a, 0);
    chk("R1", "illegal in reset", out_illegal, 0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "valid after reset", out_valid, 0);
    chk("R1", "we_b after reset", out_we_b, 0);
  endtask

  task automatic t_latency;
    in_valid = 1'b0; in_op = 4'd1;
    @(negedge clk);
    chk("R2", "idle valid", out_valid, 0);
    chk("R2", "idle we_a", out_we_a, 0);
    issue(4'd3, 1'b0, 3'd2, 3'd3, 3'd0, 16'h00FF, 16'h0F0F, 16'h0, 16'h0);
    chk("R2", "one-cycle valid", out_valid, 1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R2", "drop valid", out_valid, 0);
    chk("R2", "drop we_a", out_we_a, 0);
    issue(4'd0, 1'b0, 3'd1, 3'd2, 3'd3, 16'h5555, 16'h1, 16'h2, 16'h3);
    chk("R3", "nop valid", out_valid, 1);
    chk("R3", "nop we_a", out_we_a, 0);
    chk("R3", "nop we_b", out_we_b, 0);
    chk("R3", "nop illegal", out_illegal, 0);
  endtask

  task automatic t_self_inverse;
    for (int d = 0; d < 2; d++) begin
      issue(4'd1, d[0], 3'd4, 3'd5, 3'd6, 16'hA5C3, 16'h0, 16'h0, 16'h0);
      expect_a("R4 not", 3'd4, 16'h5A3C);
      issue(4'd3, d[0], 3'd0, 3'd1, 3'd2, 16'hF00F, 16'h3C3C, 16'h0, 16'h0);
      expect_a("R4 xor", 3'd0, 16'hCC33);
      issue(4'd8, d[0], 3'd7, 3'd0, 3'd0, 16'h1234, 16'h0, 16'h0, 16'h00FF);
      expect_a("R4 xori", 3'd7, 16'h12CB);
      issue(4'd13, d[0], 3'd1, 3'd2, 3'd3, 16'h0F0F, 16'hFF00, 16'hF0F0, 16'h0);
      expect_a("R4 ccn", 3'd1, 16'h0F0F ^ (16'hFF00 & 16'hF0F0));
    end
  endtask

  task automatic t_arith;
    issue(4'd4, 1'b0, 3'd1, 3'd2, 3'd0, 16'hFFF0, 16'h0025, 16'h0, 16'h0);
    expect_a("R5 add wrap", 3'd1, 16'h0015);
    issue(4'd5, 1'b0, 3'd1, 3'd2, 3'd0, 16'h0010, 16'h0025, 16'h0, 16'h0);
    expect_a("R5 sub wrap", 3'd1, 16'hFFEB);
    issue(4'd4, 1'b1, 3'd3, 3'd4, 3'd0, 16'h0010, 16'h0025, 16'h0, 16'h0);
    expect_a("R5 add reversed", 3'd3, 16'hFFEB);
    issue(4'd5, 1'b1, 3'd3, 3'd4, 3'd0, 16'hFFF0, 16'h0025, 16'h0, 16'h0);
    expect_a("R5 sub reversed", 3'd3, 16'h0015);
    issue(4'd9, 1'b0, 3'd6, 3'd0, 3'd0, 16'h8000, 16'h0, 16'h0, 16'h8001);
    expect_a("R5 addi", 3'd6, 16'h0001);
    issue(4'd9, 1'b1, 3'd6, 3'd0, 3'd0, 16'h0001, 16'h0, 16'h0, 16'h8001);
    expect_a("R5 addi reversed", 3'd6, 16'h8000);
    issue(4'd10, 1'b0, 3'd7, 3'd0, 3'd0, 16'h0000, 16'h0, 16'h0, 16'h0001);
    expect_a("R5 subi", 3'd7, 16'hFFFF);
    issue(4'd10, 1'b1, 3'd7, 3'd0, 3'd0, 16'hFFFF, 16'h0, 16'h0, 16'h0001);
    expect_a("R5 subi reversed", 3'd7, 16'h0000);
  endtask

  task automatic t_rotate;
    logic [15:0] x;
    x = 16'h8421;
    issue(4'd6, 1'b0, 3'd2, 3'd3, 3'd0, x, 16'd1, 16'h0, 16'h0);
    expect_a("R6 rotl 1", 3'd2, ref_rotl(x, 1));
    issue(4'd7, 1'b0, 3'd2, 3'd3, 3'd0, x, 16'd15, 16'h0, 16'h0);
    expect_a("R6 rotr 15", 3'd2, ref_rotr(x, 15));
    issue(4'd6, 1'b0, 3'd2, 3'd3, 3'd0, x, 16'd0, 16'h0, 16'h0);
    expect_a("R6 rotl 0", 3'd2, x);
    issue(4'd6, 1'b0, 3'd2, 3'd3, 3'd0, x, 16'd19, 16'h0, 16'h0);
    expect_a("R6 rotl mod16", 3'd2, ref_rotl(x, 3));
    issue(4'd6, 1'b1, 3'd2, 3'd3, 3'd0, x, 16'd5, 16'h0, 16'h0);
    expect_a("R6 rotl reversed", 3'd2, ref_rotr(x, 5));
    issue(4'd11, 1'b0, 3'd5, 3'd0, 3'd0, 16'h00F1, 16'h0, 16'h0, 16'h0024);
    expect_a("R6 rotli mod16", 3'd5, ref_rotl(16'h00F1, 4));
    issue(4'd12, 1'b1, 3'd5, 3'd0, 3'd0, 16'h00F1, 16'h0, 16'h0, 16'd7);
    expect_a("R6 rotri reversed", 3'd5, ref_rotl(16'h00F1, 7));
    issue(4'd12, 1'b0, 3'd5, 3'd0, 3'd0, 16'h00F1, 16'h0, 16'h0, 16'd7);
    expect_a("R6 rotri", 3'd5, ref_rotr(16'h00F1, 7));
  endtask

  task automatic t_swaps;
    for (int d = 0; d < 2; d++) begin
      issue(4'd2, d[0], 3'd6, 3'd7, 3'd0, 16'hBEEF, 16'h1357, 16'h0, 16'h0);
      expect_ab("R7 swap", 3'd6, 16'h1357, 3'd7, 16'hBEEF);
      issue(4'd14, d[0], 3'd0, 3'd3, 3'd5, 16'h00FF, 16'hAAAA, 16'h5555, 16'h0);
      expect_ab("R8 cswap", 3'd3, 16'hAA55, 3'd5, 16'h55AA);
    end
    issue(4'd14, 1'b0, 3'd0, 3'd3, 3'd5, 16'h0000, 16'hAAAA, 16'h5555, 16'h0);
    expect_ab("R8 cswap empty mask", 3'd3, 16'hAAAA, 3'd5, 16'h5555);
  endtask

  task automatic t_illegal;
    issue(4'd3, 1'b0, 3'd2, 3'd2, 3'd0, 16'h1111, 16'h1111, 16'h0, 16'h0);
    expect_reject("R9 xor alias");
    issue(4'd5, 1'b1, 3'd4, 3'd4, 3'd0, 16'h2222, 16'h2222, 16'h0, 16'h0);
    expect_reject("R9 sub alias");
    issue(4'd4, 1'b0, 3'd1, 3'd1, 3'd0, 16'h0003, 16'h0003, 16'h0, 16'h0);
    expect_reject("R9 add alias");
    issue(4'd6, 1'b0, 3'd7, 3'd7, 3'd0, 16'h0003, 16'h0003, 16'h0, 16'h0);
    expect_reject("R9 rotl alias");
    issue(4'd13, 1'b0, 3'd3, 3'd1, 3'd3, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0);
    expect_reject("R9 ccn alias");
    issue(4'd15, 1'b0, 3'd0, 3'd1, 3'd2, 16'h1, 16'h2, 16'h3, 16'h4);
    expect_reject("R9 reserved");
    issue(4'd9, 1'b0, 3'd2, 3'd2, 3'd0, 16'h0001, 16'h0001, 16'h0, 16'h0002);
    expect_a("R9 imm form allowed", 3'd2, 16'h0003);
  endtask

  task automatic t_roundtrip;
    logic [15:0] orig, mid;
    logic [3:0]  ops [6];
    ops[0] = 4'd4; ops[1] = 4'd5; ops[2] = 4'd6;
    ops[3] = 4'd7; ops[4] = 4'd3; ops[5] = 4'd13;
    orig = 16'hC0DE;
    for (int k = 0; k < 6; k++) begin
      issue(ops[k], 1'b0, 3'd1, 3'd2, 3'd3, orig, 16'h9A7B, 16'h3F0C, 16'h0);
      mid = out_val_a;
      issue(ops[k], 1'b1, 3'd1, 3'd2, 3'd3, mid, 16'h9A7B, 16'h3F0C, 16'h0);
      chk("R10", "restored", out_val_a, orig);
    end
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_latency();
    t_self_inverse();
    t_arith();
    t_rotate();
    t_swaps();
    t_illegal();
    t_roundtrip();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule